// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins behind a small register file. Software reaches it through a word-indexed request channel: each request carries a word index, a write flag and write data, and every read is answered one cycle later on a response channel. Each pin is either an input or an output. An input can flag an interrupt on a chosen edge or on a chosen level. An output drives one of four values, picked in this order of priority: a battery-fault value, a sleep value, a peripheral value (when the pin is handed to an alternate function), or the plain output register.

Every input first passes two synchroniser flops. A third flop holds the previous synchronised value for edge detection. Detections set sticky per-pin status bits. Software clears a bit by writing 1 to it. A single `irq` line is high while any status bit is set and not masked. In sleep, a second mask can also silence pins.

The request channel never applies back-pressure: `req_ready` is always 1, so a request is taken on every clock edge where `req_valid` is high. The response channel has no ready signal. The consumer must accept `rsp_valid` in the cycle it appears.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, `pin_oe`, `pin_out`, `irq` and `rsp_valid` are 0. After reset, every register reads 0.
- R2: Register word indices are: 0 interrupt mask, 1 direction, 2 output, 3 trigger type, 4 edge polarity, 5 level polarity, 6 sleep mask, 7 sleep output, 8 fault output, 9 interrupt status, 10 alternate select, 11 sleep config, 12 pin status. A write to indices 0–8, 10 or 11 is stored. A read taken at one edge returns that register with `rsp_valid`=1 after the next edge.
- R3: `pin_oe` equals the direction register (1 = output). In normal mode, a pin without its alternate bit drives its output-register bit (0 = low).
- R4: A pin whose alternate-select bit is 1 drives `alt_out` for that pin in place of its output-register bit.
- R5: When `sleep_mode`=1, or when bit 1 of the sleep config is 1, `pin_out` takes the sleep output register. Other bits of the sleep config have no effect.
- R6: When `batt_fault`=1, `pin_out` equals the fault output register, whatever the sleep state.
- R7: An input pin whose trigger-type bit is 0 sets its status bit while its synchronised value equals its level-polarity bit (0 = low, 1 = high).
- R8: An input pin whose trigger-type bit is 1 sets its status bit on a synchronised edge: falling when its edge-polarity bit is 0, rising when it is 1. The other edge has no effect. After a pin change just before clock edge k, the status bit and `irq` become visible just after edge k+2.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a detection happens in the same cycle, the set takes priority, so a persisting level condition re-asserts at once.
- R10: `irq` is the OR of status bits whose mask bit is 0. While `sleep_mode`=1, sleep-mask bits set to 1 also suppress. A masked pin still records status.
- R11: Index 12 reads the synchronised pin values, and writes to it are ignored.
- R12: A pin whose direction bit is 1 never sets its status bit.
- R13: Indices 13–15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1: requests are never stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 4 | Register word index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 16 | Read data |
| pin_in | input | 16 | Raw pin levels from the pads |
| alt_out | input | 16 | Peripheral output values for alternate-function pins |
| sleep_mode | input | 1 | System is in sleep |
| batt_fault | input | 1 | Battery fault present |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Register effects on `pin_out`, `pin_oe` and `irq` appear just after the edge that takes the write. Read data appears just after the edge that takes the read. Changes to `sleep_mode`, `batt_fault` and `alt_out` pass through without any register. A pin change reaches status and `irq` after the third edge. The bench checks `irq` one cycle too early (expecting 0) and then on time (expecting 1). All stimulus is driven on falling clock edges, and each result is sampled on the falling edge after the rising edge at which it is due. Read results are sampled only after the response cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_MASK  = 4'd0,
    IDX_DIR   = 4'd1,
    IDX_OUT   = 4'd2,
    IDX_TRIG  = 4'd3,
    IDX_EPOL  = 4'd4,
    IDX_LPOL  = 4'd5,
    IDX_SMASK = 4'd6,
    IDX_SOUT  = 4'd7,
    IDX_BFOUT = 4'd8,
    IDX_STAT  = 4'd9,
    IDX_ALT   = 4'd10,
    IDX_SCFG  = 4'd11,
    IDX_PIN   = 4'd12
  } reg_idx_e;

  localparam int unsigned NUM_STORED = 12;
  localparam int unsigned AUTOSLEEP_BIT = 1;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_word,
  input  logic [NPINS-1:0] req_wdata,
  input  logic [NPINS-1:0] hit_vec,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] trig_o,
  output logic [NPINS-1:0] epol_o,
  output logic [NPINS-1:0] lpol_o,
  output logic [NPINS-1:0] smask_o,
  output logic [NPINS-1:0] sout_o,
  output logic [NPINS-1:0] bfout_o,
  output logic [NPINS-1:0] alt_o,
  output logic             autosleep_o,
  output logic [NPINS-1:0] status_o,
  output logic             rsp_valid,
  output logic [NPINS-1:0] rsp_rdata
);
  localparam logic [IDX_W-1:0] LAST_STORED = IDX_W'(NUM_STORED - 1);

  logic [NPINS-1:0] store_q [NUM_STORED];
  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] rd_mux;
  logic             wr_en;
  logic             rd_en;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NUM_STORED); k++) store_q[k] <= '0;
    end else if (wr_en && (req_word <= LAST_STORED) && (req_word != IDX_STAT)) begin
      store_q[req_word] <= req_wdata;
    end
  end

  assign clr_vec = (wr_en && (req_word == IDX_STAT)) ? req_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | hit_vec;
  end

  always_comb begin
    rd_mux = '0;
    if (req_word == IDX_STAT)          rd_mux = status_q;
    else if (req_word == IDX_PIN)      rd_mux = pin_sync;
    else if (req_word <= LAST_STORED)  rd_mux = store_q[req_word];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

  assign mask_o      = store_q[IDX_MASK];
  assign dir_o       = store_q[IDX_DIR];
  assign out_o       = store_q[IDX_OUT];
  assign trig_o      = store_q[IDX_TRIG];
  assign epol_o      = store_q[IDX_EPOL];
  assign lpol_o      = store_q[IDX_LPOL];
  assign smask_o     = store_q[IDX_SMASK];
  assign sout_o      = store_q[IDX_SOUT];
  assign bfout_o     = store_q[IDX_BFOUT];
  assign alt_o       = store_q[IDX_ALT];
  assign autosleep_o = store_q[IDX_SCFG][AUTOSLEEP_BIT];
  assign status_o    = status_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] trig,
  input  logic [NPINS-1:0] epol,
  input  logic [NPINS-1:0] lpol,
  output logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] hit_vec
);
  logic [NPINS-1:0] chain_q [SYNC_STAGES];
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SYNC_STAGES); s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= pin_in;
      for (int s = 1; s < int'(SYNC_STAGES); s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[SYNC_STAGES-1];
    end
  end

  assign pin_sync = chain_q[SYNC_STAGES-1];

  for (genvar i = 0; i < int'(NPINS); i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = pin_sync[i] & ~prev_q[i];
    assign fall     = ~pin_sync[i] & prev_q[i];
    assign edge_hit = epol[i] ? rise : fall;
    assign lvl_hit  = (pin_sync[i] == lpol[i]);
    assign hit_vec[i] = ~dir[i] & (trig[i] ? edge_hit : lvl_hit);
  end
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
  parameter int unsigned NPINS = 16
) (
  input  logic [NPINS-1:0] out_reg,
  input  logic [NPINS-1:0] alt_sel,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] sout,
  input  logic [NPINS-1:0] bfout,
  input  logic             sleep_mode,
  input  logic             autosleep,
  input  logic             batt_fault,
  output logic [NPINS-1:0] pin_out
);
  logic use_sleep;
  assign use_sleep = sleep_mode | autosleep;

  for (genvar i = 0; i < int'(NPINS); i++) begin : g_pin
    logic normal_v;
    assign normal_v = alt_sel[i] ? alt_out[i] : out_reg[i];
    always_comb begin
      if (batt_fault)     pin_out[i] = bfout[i];
      else if (use_sleep) pin_out[i] = sout[i];
      else                pin_out[i] = normal_v;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_word,
  input  logic [NPINS-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [NPINS-1:0] rsp_rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] alt_out,
  input  logic             sleep_mode,
  input  logic             batt_fault,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [NPINS-1:0] mask_q, dir_q, out_q, trig_q, epol_q, lpol_q;
  logic [NPINS-1:0] smask_q, sout_q, bfout_q, alt_q, status_q;
  logic [NPINS-1:0] pin_sync, hit_vec, eff_mask;
  logic             autosleep;

  assign req_ready = 1'b1;

  gpio_regfile #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .hit_vec(hit_vec), .pin_sync(pin_sync),
    .mask_o(mask_q), .dir_o(dir_q), .out_o(out_q), .trig_o(trig_q),
    .epol_o(epol_q), .lpol_o(lpol_q), .smask_o(smask_q), .sout_o(sout_q),
    .bfout_o(bfout_q), .alt_o(alt_q), .autosleep_o(autosleep),
    .status_o(status_q), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  gpio_detect #(.NPINS(NPINS), .SYNC_STAGES(2)) det_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir_q),
    .trig(trig_q), .epol(epol_q), .lpol(lpol_q),
    .pin_sync(pin_sync), .hit_vec(hit_vec)
  );

  gpio_outmux #(.NPINS(NPINS)) mux_i (
    .out_reg(out_q), .alt_sel(alt_q), .alt_out(alt_out), .sout(sout_q),
    .bfout(bfout_q), .sleep_mode(sleep_mode), .autosleep(autosleep),
    .batt_fault(batt_fault), .pin_out(pin_out)
  );

  assign pin_oe   = dir_q;
  assign eff_mask = mask_q | (sleep_mode ? smask_q : '0);
  assign irq      = |(status_q & ~eff_mask);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             irq,
  input logic             batt_fault,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] bfout
);
  // R2
  read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);

  // R12
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & $past(dir)) == '0));

  // R6
  fault_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_fault |-> (pin_out == bfout));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .irq(irq), .batt_fault(batt_fault),
  .status(status_q), .dir(dir_q), .pin_out(pin_out), .bfout(bfout_q)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]    req_word = '0;
  logic [NP-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, irq;
  logic [NP-1:0] rsp_rdata, pin_out, pin_oe;
  logic [NP-1:0] pin_in = 16'hFFFF, alt_out = '0;
  logic          sleep_mode = 1'b0, batt_fault = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .alt_out(alt_out), .sleep_mode(sleep_mode), .batt_fault(batt_fault),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {word, write data, expected readback}
  localparam logic [35:0] VEC [13] = '{
    {4'd0,  16'hA5A5, 16'hA5A5},
    {4'd1,  16'h0F0F, 16'h0F0F},
    {4'd2,  16'h3C3C, 16'h3C3C},
    {4'd3,  16'h1111, 16'h1111},
    {4'd4,  16'h2222, 16'h2222},
    {4'd5,  16'h4444, 16'h4444},
    {4'd6,  16'h8888, 16'h8888},
    {4'd7,  16'h1357, 16'h1357},
    {4'd8,  16'h2468, 16'h2468},
    {4'd10, 16'h9999, 16'h9999},
    {4'd11, 16'h0002, 16'h0002},
    {4'd12, 16'h1234, 16'hFFFF},
    {4'd13, 16'hBEEF, 16'h0000}
  };

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [NP-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [NP-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      errors++; checks++;
      $display("FAIL R2: rsp_valid actual=0 expected=1");
    end
    d = rsp_rdata;
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg_zero();
    for (int k = 0; k <= 11; k++) if (k != 9) wr(4'(k), '0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [NP-1:0] d;
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    rst_n = 1'b1;
    idle(2);
    rd(4'd0, d); check("R1 mask after reset", d, '0);
    rd(4'd8, d); check("R1 fault out after reset", d, '0);
    check("R2 req_ready", {15'd0, req_ready}, 16'd1);

    // R2 R11 R13: table of register writes and readbacks
    for (int v = 0; v < 13; v++) begin
      wr(VEC[v][35:32], VEC[v][31:16]);
      rd(VEC[v][35:32], d);
      check($sformatf("R2/R11/R13 word %0d", VEC[v][35:32]), d, VEC[v][15:0]);
    end
    rd(4'd15, d); check("R13 word 15", d, '0);

    // R3 R4 R5 R6: output selection
    cfg_zero();
    alt_out = 16'h0033;
    wr(4'd1, 16'h00FF);
    wr(4'd2, 16'h00A5);
    check("R3 pin_oe follows direction", pin_oe, 16'h00FF);
    check("R3 output register drives", pin_out, 16'h00A5);
    wr(4'd10, 16'h000F);
    check("R4 alternate select", pin_out, 16'h00A3);
    wr(4'd7, 16'h5A5A);
    @(negedge clk); sleep_mode = 1'b1;
    @(negedge clk); check("R5 sleep output in sleep", pin_out, 16'h5A5A);
    sleep_mode = 1'b0;
    @(negedge clk); check("R5 normal mode", pin_out, 16'h00A3);
    wr(4'd11, 16'h0002); check("R5 autosleep bit", pin_out, 16'h5A5A);
    wr(4'd11, 16'h0001); check("R5 other config bit", pin_out, 16'h00A3);
    wr(4'd8, 16'hC3C3);
    @(negedge clk); sleep_mode = 1'b1; batt_fault = 1'b1;
    @(negedge clk); check("R6 fault over sleep", pin_out, 16'hC3C3);
    sleep_mode = 1'b0; batt_fault = 1'b0;

    // R8 R9: edge detection and timing
    cfg_zero();
    wr(4'd3, 16'hFFFF);
    idle(3);
    wr(4'd9, 16'hFFFF);
    rd(4'd9, d); check("R9 cleared", d, '0);
    check("R10 irq idle", {15'd0, irq}, 16'd0);
    set_pins(16'hFFFE);
    idle(2); check("R8 irq not before third edge", {15'd0, irq}, 16'd0);
    idle(1); check("R8 irq after third edge", {15'd0, irq}, 16'd1);
    rd(4'd9, d); check("R8 falling edge status", d, 16'h0001);
    wr(4'd9, 16'h0001);
    rd(4'd9, d); check("R9 write-1 clears", d, '0);
    set_pins(16'hFFFF); idle(4);
    rd(4'd9, d); check("R8 rising ignored when falling selected", d, '0);
    wr(4'd4, 16'h0001);
    set_pins(16'hFFFE); idle(4);
    rd(4'd9, d); check("R8 falling ignored when rising selected", d, '0);
    set_pins(16'hFFFF); idle(4);
    rd(4'd9, d); check("R8 rising edge status", d, 16'h0001);
    wr(4'd9, 16'h0001);
    wr(4'd4, 16'h0000);

    // R7 R9: level detection
    wr(4'd3, 16'hFFEF);
    wr(4'd5, 16'h0010);
    idle(2);
    rd(4'd9, d); check("R7 level-high status", d, 16'h0010);
    wr(4'd9, 16'h0010);
    rd(4'd9, d); check("R9 level re-asserts", d, 16'h0010);
    wr(4'd5, 16'h0000);
    wr(4'd9, 16'h0010);
    rd(4'd9, d); check("R7 no hit once condition gone", d, '0);
    set_pins(16'hFFEF); idle(4);
    rd(4'd9, d); check("R7 level-low status", d, 16'h0010);
    set_pins(16'hFFFF); idle(4);
    wr(4'd9, 16'h0010);

    // R10: masking
    wr(4'd0, 16'h0002);
    set_pins(16'hFFFD); idle(4);
    check("R10 masked pin no irq", {15'd0, irq}, 16'd0);
    rd(4'd9, d); check("R10 masked pin records status", d, 16'h0002);
    wr(4'd0, 16'h0000);
    check("R10 unmask raises irq", {15'd0, irq}, 16'd1);
    wr(4'd6, 16'h0002);
    check("R10 sleep mask idle outside sleep", {15'd0, irq}, 16'd1);
    @(negedge clk); sleep_mode = 1'b1;
    @(negedge clk); check("R10 sleep mask in sleep", {15'd0, irq}, 16'd0);
    sleep_mode = 1'b0;
    set_pins(16'hFFFF); idle(4);
    wr(4'd9, 16'hFFFF); wr(4'd6, 16'h0000);

    // R12: output pins do not detect
    wr(4'd1, 16'h0004);
    set_pins(16'hFFFB); idle(4);
    rd(4'd9, d); check("R12 output pin no status", d, '0);
    check("R12 output pin no irq", {15'd0, irq}, 16'd0);
    set_pins(16'hFFFF); idle(4);
    wr(4'd1, 16'h0000);

    // R11: pin status
    wr(4'd0, 16'hFFFF);
    set_pins(16'hA5C3); idle(3);
    rd(4'd12, d); check("R11 pin status", d, 16'hA5C3);

    done = 1'b1;
    finish_run();
  end
endmodule